// File: doc/BRIEF.md
# Modem Handshake Output and Loopback Controller

This block sits beside one serial channel and turns the handshake bits of a modem control register into the channel's pins. It drives active-low data-terminal-ready, request-to-send and a general-purpose user output. It also drives the interrupt pin together with a tri-state enable, so that several channels can share an interrupt line when their pins are released.

The block watches the active-low ring-indicator pin. The pin is first synchronized into the clock domain. A release of the ring signal, seen as a low-to-high level on the pin, sets a pending modem-status flag. The flag raises an interrupt request when that source is enabled, and it stays set until the status register is read.

A loopback control bit isolates the channel from the line for self-test. In loopback the transmit serial stream is fed straight into the receiver and the line input is ignored. The outgoing transmit pin rests at the mark level, and the handshake outputs fall back to their inactive state.

Top module: `mdm_ctl_out`

## Requirements
- R1: While reset is high, and on the first clock edge after it is asserted, `dtr_n`, `rts_n` and `op_n` are 1, and `irq_oe`, `irq_o` and `msi_req` are 0.
- R2: Outside loopback, `dtr_n` equals the inverse of `mcr_dtr` one clock edge after the bit is presented.
- R3: Outside loopback, `rts_n` equals the inverse of `mcr_rts` one clock edge after the bit is presented.
- R4: One clock edge after `mcr_out2` is presented, `irq_oe` equals it. Outside loopback, `op_n` equals its inverse.
- R5: When `irq_oe` is 1, `irq_o` carries `irq_req` delayed by one clock edge. When `irq_oe` is 0, `irq_o` is 0.
- R6: A low-to-high level change on `ring_n` sets the pending ring flag SYNC_STAGES+1 clock edges after the change, and not earlier. A high-to-low change never sets it.
- R7: `msi_req` is 1 exactly when the pending ring flag is set and `ms_irq_en` is 1. A pending flag survives while the enable is 0.
- R8: A clock edge with `msr_rd` at 1 clears the pending flag, unless a new rising ring level is detected on that same edge, in which case the flag stays set.
- R9: While `mcr_loop` is 1, `rx_ser` equals `tx_ser` combinationally and `rx_pin` has no effect on it. While `mcr_loop` is 0, `rx_ser` equals `rx_pin`.
- R10: While `mcr_loop` is 1, `tx_pin` is 1. One edge after loopback is presented, `dtr_n`, `rts_n` and `op_n` are 1 whatever their bits are, while `irq_oe` still follows `mcr_out2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_dtr | input | 1 | Terminal-ready control bit |
| mcr_rts | input | 1 | Request-to-send control bit |
| mcr_out2 | input | 1 | Interrupt-pin enable and user output control bit |
| mcr_loop | input | 1 | Loopback control bit |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| msr_rd | input | 1 | Strobe marking a read of the modem status register |
| ring_n | input | 1 | Ring-indicator pin, active low, asynchronous |
| tx_ser | input | 1 | Serial data from the transmitter |
| rx_pin | input | 1 | Serial line input pin |
| irq_req | input | 1 | Combined internal interrupt request |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| op_n | output | 1 | User output pin, active low |
| irq_o | output | 1 | Interrupt pin value, active high |
| irq_oe | output | 1 | Interrupt pin drive enable (0 = high impedance) |
| rx_ser | output | 1 | Serial data to the receiver |
| tx_pin | output | 1 | Serial line output pin |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach from the ports is a status-register read that lands on the same edge as a newly detected ring release. The flag must survive that edge, but a read and a detection are separated by the synchronizer delay. The bench counts exactly SYNC_STAGES edges after raising `ring_n` and pulses `msr_rd` on the following edge, then checks that `msi_req` remains set. A second read then clears it. The other ring tests place the rising level before and after the detection edge, so that an off-by-one in the synchronizer depth shows up as an early or late flag.

// File: rtl/mdm_ctl_out.sv
module mdm_ctl_out #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mcr_dtr,
  input  logic mcr_rts,
  input  logic mcr_out2,
  input  logic mcr_loop,
  input  logic ms_irq_en,
  input  logic msr_rd,
  input  logic ring_n,
  input  logic tx_ser,
  input  logic rx_pin,
  input  logic irq_req,
  output logic dtr_n,
  output logic rts_n,
  output logic op_n,
  output logic irq_o,
  output logic irq_oe,
  output logic rx_ser,
  output logic tx_pin,
  output logic msi_req
);
  localparam int MSB = (SYNC_STAGES < 2) ? 1 : SYNC_STAGES - 1;

  logic [MSB:0] ri_sync;
  logic         ri_last;
  logic         ri_flag;
  logic         ri_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ri_sync <= '1;
      ri_last <= 1'b1;
    end else begin
      ri_sync <= {ri_sync[MSB-1:0], ring_n};
      ri_last <= ri_sync[MSB];
    end
  end

  assign ri_rise = ri_sync[MSB] & ~ri_last;

  always_ff @(posedge clk) begin
    if (rst)          ri_flag <= 1'b0;
    else if (ri_rise) ri_flag <= 1'b1;
    else if (msr_rd)  ri_flag <= 1'b0;
  end

  assign msi_req = ri_flag & ms_irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_n  <= 1'b1;
      rts_n  <= 1'b1;
      op_n   <= 1'b1;
      irq_oe <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      dtr_n  <= mcr_loop | ~mcr_dtr;
      rts_n  <= mcr_loop | ~mcr_rts;
      op_n   <= mcr_loop | ~mcr_out2;
      irq_oe <= mcr_out2;
      irq_o  <= mcr_out2 & irq_req;
    end
  end

  assign rx_ser = mcr_loop ? tx_ser : rx_pin;
  assign tx_pin = mcr_loop | tx_ser;
endmodule

// File: rtl/mdm_ctl_out_chk.sv
module mdm_ctl_out_chk (
  input logic clk,
  input logic rst,
  input logic mcr_out2,
  input logic mcr_loop,
  input logic ms_irq_en,
  input logic msr_rd,
  input logic tx_ser,
  input logic dtr_n,
  input logic rts_n,
  input logic op_n,
  input logic irq_o,
  input logic irq_oe,
  input logic rx_ser,
  input logic tx_pin,
  input logic msi_req,
  input logic ri_rise,
  input logic ri_flag
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (dtr_n && rts_n && op_n && !irq_oe && !irq_o && !msi_req));

  assert_oe_follows_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_oe == $past(mcr_out2)));

  assert_released_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !irq_oe |-> !irq_o);

  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (rst)
    ri_rise |=> ri_flag);

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
    !ms_irq_en |-> !msi_req);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && !ri_rise) |=> !ri_flag);

  assert_loop_route_R9: assert property (@(posedge clk) disable iff (rst)
    mcr_loop |-> (rx_ser == tx_ser));

  assert_loop_mark_R10: assert property (@(posedge clk) disable iff (rst)
    mcr_loop |-> tx_pin);

  assert_loop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    mcr_loop |=> (dtr_n && rts_n && op_n));
endmodule

bind mdm_ctl_out mdm_ctl_out_chk u_chk (
  .clk(clk), .rst(rst), .mcr_out2(mcr_out2), .mcr_loop(mcr_loop),
  .ms_irq_en(ms_irq_en), .msr_rd(msr_rd), .tx_ser(tx_ser),
  .dtr_n(dtr_n), .rts_n(rts_n), .op_n(op_n), .irq_o(irq_o),
  .irq_oe(irq_oe), .rx_ser(rx_ser), .tx_pin(tx_pin), .msi_req(msi_req),
  .ri_rise(ri_rise), .ri_flag(ri_flag)
);

// File: tb/sim_mdm_ctl_out.sv
`timescale 1ns/1ps
module sim_mdm_ctl_out;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mcr_dtr = 0, mcr_rts = 0, mcr_out2 = 0, mcr_loop = 0;
  logic ms_irq_en = 0, msr_rd = 0, ring_n = 1, tx_ser = 1, rx_pin = 1, irq_req = 0;
  logic dtr_n, rts_n, op_n, irq_o, irq_oe, rx_ser, tx_pin, msi_req;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mdm_ctl_out #(.SYNC_STAGES(SYNC_STAGES)) u0 (
    .clk(clk), .rst(rst), .mcr_dtr(mcr_dtr), .mcr_rts(mcr_rts),
    .mcr_out2(mcr_out2), .mcr_loop(mcr_loop), .ms_irq_en(ms_irq_en),
    .msr_rd(msr_rd), .ring_n(ring_n), .tx_ser(tx_ser), .rx_pin(rx_pin),
    .irq_req(irq_req), .dtr_n(dtr_n), .rts_n(rts_n), .op_n(op_n),
    .irq_o(irq_o), .irq_oe(irq_oe), .rx_ser(rx_ser), .tx_pin(tx_pin),
    .msi_req(msi_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1; mcr_dtr = 1; mcr_rts = 1; mcr_out2 = 1; irq_req = 1; ms_irq_en = 1;
    tick(2);
    chk("R1 dtr_n", dtr_n, 1'b1);
    chk("R1 rts_n", rts_n, 1'b1);
    chk("R1 op_n", op_n, 1'b1);
    chk("R1 irq_oe", irq_oe, 1'b0);
    chk("R1 irq_o", irq_o, 1'b0);
    chk("R1 msi_req", msi_req, 1'b0);
    mcr_dtr = 0; mcr_rts = 0; mcr_out2 = 0; irq_req = 0; ms_irq_en = 0;
    rst = 0;
    tick(1);
  endtask

  task automatic t_dtr_rts;
    mcr_dtr = 1; mcr_rts = 0;
    tick(1);
    chk("R2 dtr_n low", dtr_n, 1'b0);
    chk("R3 rts_n high", rts_n, 1'b1);
    mcr_dtr = 0; mcr_rts = 1;
    tick(1);
    chk("R2 dtr_n high", dtr_n, 1'b1);
    chk("R3 rts_n low", rts_n, 1'b0);
    mcr_rts = 0;
    tick(1);
    chk("R3 rts_n released", rts_n, 1'b1);
  endtask

  task automatic t_out2_irq;
    irq_req = 1;
    tick(1);
    chk("R4 oe off", irq_oe, 1'b0);
    chk("R4 op_n high", op_n, 1'b1);
    chk("R5 irq_o quiet", irq_o, 1'b0);
    mcr_out2 = 1;
    tick(1);
    chk("R4 oe on", irq_oe, 1'b1);
    chk("R4 op_n low", op_n, 1'b0);
    chk("R5 irq_o high", irq_o, 1'b1);
    irq_req = 0;
    @(posedge clk); #1;
    chk("R5 irq_o after edge", irq_o, 1'b0);
    @(negedge clk);
    mcr_out2 = 0;
    tick(1);
    chk("R4 oe released", irq_oe, 1'b0);
  endtask

  task automatic t_ring;
    ring_n = 0;
    tick(SYNC_STAGES + 3);
    chk("R6 falling sets nothing", msi_req, 1'b0);
    ms_irq_en = 0;
    ring_n = 1;
    tick(SYNC_STAGES);
    ms_irq_en = 1;
    #1 chk("R6 not early", msi_req, 1'b0);
    ms_irq_en = 0;
    tick(1);
    chk("R7 gated off", msi_req, 1'b0);
    ms_irq_en = 1;
    #1 chk("R6 set on time / R7 enable", msi_req, 1'b1);
    tick(3);
    chk("R7 held pending", msi_req, 1'b1);
    msr_rd = 1;
    tick(1);
    msr_rd = 0;
    chk("R8 read clears", msi_req, 1'b0);
  endtask

  task automatic t_clear_race;
    ring_n = 0;
    tick(SYNC_STAGES + 2);
    ring_n = 1;
    tick(SYNC_STAGES);
    msr_rd = 1;
    tick(1);
    msr_rd = 0;
    chk("R8 set wins over read", msi_req, 1'b1);
    msr_rd = 1;
    tick(1);
    msr_rd = 0;
    chk("R8 second read clears", msi_req, 1'b0);
  endtask

  task automatic t_loop;
    mcr_loop = 0; rx_pin = 0; tx_ser = 1;
    #1 chk("R9 normal rx", rx_ser, 1'b0);
    chk("R10 normal tx", tx_pin, 1'b1);
    tx_ser = 0;
    #1 chk("R10 normal tx low", tx_pin, 1'b0);
    mcr_dtr = 1; mcr_rts = 1; mcr_out2 = 1; mcr_loop = 1; rx_pin = 1;
    #1 chk("R9 loop rx follows tx low", rx_ser, 1'b0);
    chk("R10 tx mark", tx_pin, 1'b1);
    tick(1);
    chk("R10 dtr_n idle", dtr_n, 1'b1);
    chk("R10 rts_n idle", rts_n, 1'b1);
    chk("R10 op_n idle", op_n, 1'b1);
    chk("R10 oe follows bit", irq_oe, 1'b1);
    tx_ser = 1; rx_pin = 0;
    #1 chk("R9 loop rx follows tx high", rx_ser, 1'b1);
    mcr_loop = 0;
    tick(1);
    chk("R2 dtr_n after loop", dtr_n, 1'b0);
    chk("R9 back to pin", rx_ser, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_dtr_rts();
    t_out2_irq();
    t_ring();
    t_clear_race();
    t_loop();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule